// File: doc/BRIEF.md
# Scan Motion Command Sequencer

This block turns writes to a small command register into the motion and scan state of a document scanner. Each write carries a 3-bit operation code, a standby bit and a software-reset bit. From the operation code the sequencer runs one of six behaviours:

- stay idle;
- feed the carriage forward or backward until told to stop;
- clear the image data pointers and then scan;
- feed forward or backward for a preset number of lines, then stop by itself.

It does not generate motor phases. It drives a step-enable, a direction and a step-size value to a separate phase generator. It also raises a scan-active flag and a one-cycle pointer-clear pulse for the image path.

Line boundaries come from the sensor timing logic as a one-cycle `line_tick`. A stop request during a scan takes effect only at the next line boundary, so no line is cut in half. Preset moves count line ticks against a 16-bit count captured when the move starts. `busy` and `cmd_status` let software wait for the idle state before it issues the next operation. Standby halts all activity at once and gates the sensor clock. A software reset is a write with the reset bit set followed by a write with it clear.

States:

| State | Meaning |
|---|---|
| ST_IDLE | No activity. |
| ST_FEED_FWD | Continuous forward feed. |
| ST_FEED_REV | Continuous reverse feed. |
| ST_PTR_CLR | One cycle in which the image pointers are cleared. |
| ST_SCAN | Scanning. |
| ST_DRAIN | A stop was requested during a scan; waiting for the line to finish. |
| ST_PROG_FWD | Preset forward move. |
| ST_PROG_REV | Preset reverse move. |

Transitions:

| From | Event | To |
|---|---|---|
| ST_IDLE | accepted code 001 | ST_FEED_FWD |
| ST_IDLE | accepted code 010 | ST_FEED_REV |
| ST_IDLE | accepted code 011 | ST_PTR_CLR |
| ST_IDLE | accepted code 101 with a nonzero count | ST_PROG_FWD |
| ST_IDLE | accepted code 110 with a nonzero count | ST_PROG_REV |
| ST_FEED_FWD, ST_FEED_REV | idle code | ST_IDLE |
| ST_PTR_CLR | idle code | ST_DRAIN |
| ST_PTR_CLR | otherwise | ST_SCAN |
| ST_SCAN | idle code | ST_DRAIN |
| ST_DRAIN | `line_tick` | ST_IDLE |
| ST_PROG_FWD, ST_PROG_REV | idle code, or `line_tick` on the last counted line | ST_IDLE |
| any state | halt (standby or software reset) | ST_IDLE |

Top module: `scan_motion_seq`

## Requirements
- R1: After `rst_n` is released, `busy`, `step_en`, `step_dir`, `scan_active` and `ptr_reset` are 0, `cmd_status` is 000 and `sensor_clk_en` is 1.
- R2: An accepted code 001 sets `step_en`=1 with `step_dir`=0 from the cycle after the write. An accepted code 010 does the same with `step_dir`=1. Both continue until an idle code is written, and stop in the cycle after that write.
- R3: The idle codes are 000, 100 and 111. All three stop a feed or a preset move in the cycle after the write.
- R4: An accepted code 011 gives exactly one cycle with `ptr_reset`=1 and `scan_active`=0. From the next cycle `scan_active`=1 and `step_en`=1 forward.
- R5: An idle code written during a scan keeps `scan_active`, `step_en` and `busy` at 1 until the next `line_tick`. All three go low in the cycle after that tick.
- R6: Codes 101 (forward) and 110 (reverse) capture `line_count` when accepted and move until that many `line_tick` pulses have been seen. The sequencer is idle in the cycle after the last tick. A count of 0 starts no move.
- R7: A non-idle code written while `busy`=1 is ignored: the state and all outputs stay as they were.
- R8: `cmd_status` shows the operation in effect: 001, 010, 011 (pointer clear and scan), 101 or 110. It shows 000 when idle and while a scan drains.
- R9: `step_size` equals `feed_step` during feeds and preset moves and is 0 in every other state.
- R10: A write with the standby bit set stops all motion and scanning from the next cycle and drives `sensor_clk_en` to 0. Any write with the standby bit clear ends standby. The operation code of that write and of standby writes is ignored.
- R11: A write with the reset bit set forces the sequencer idle and holds it there. Codes are ignored until a write with the reset bit clear; that write's code is also ignored. After it, commands are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Command register write strobe |
| reg_cmd | input | 3 | Operation code of the write |
| reg_standby | input | 1 | Standby bit of the write |
| reg_swreset | input | 1 | Software-reset bit of the write |
| line_count | input | CNT_W | Line count for preset moves |
| feed_step | input | STEP_W | Step size for feeds and preset moves |
| line_tick | input | 1 | One-cycle pulse at each line boundary |
| step_en | output | 1 | Motor stepping enabled |
| step_dir | output | 1 | Direction, 1 = reverse |
| step_size | output | STEP_W | Step size to the phase generator |
| scan_active | output | 1 | Image lines are being captured |
| ptr_reset | output | 1 | One-cycle image pointer clear |
| busy | output | 1 | Sequencer not idle |
| cmd_status | output | 3 | Operation in effect |
| sensor_clk_en | output | 1 | Sensor clocks running (low in standby) |

## Verification
On every cycle the assertions check four things:
- the pointer-clear pulse lasts one cycle and is followed by scanning;
- a draining scan cannot end without a line tick;
- a running forward feed can only continue or stop, never switch;
- the preset counter never wraps below zero, and standby keeps motion and scanning low.

Only the bench's scenarios can show the rest: ignored commands leave the outputs untouched, preset moves end on exactly the Nth tick, and a zero count starts nothing. They also show that the two-write reset and the standby exit swallow the code they carry. The bench's cycle-by-cycle model catches any drift in status encoding or step size between those points.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FEED_FWD,
        ST_FEED_REV,
        ST_PTR_CLR,
        ST_SCAN,
        ST_DRAIN,
        ST_PROG_FWD,
        ST_PROG_REV
    } seq_state_e;

    typedef enum logic [2:0] {
        K_IDLE,
        K_FWD,
        K_REV,
        K_SCAN,
        K_PFWD,
        K_PREV
    } op_kind_e;

    localparam logic [2:0] OP_IDLE     = 3'b000;
    localparam logic [2:0] OP_FEED_FWD = 3'b001;
    localparam logic [2:0] OP_FEED_REV = 3'b010;
    localparam logic [2:0] OP_SCAN     = 3'b011;
    localparam logic [2:0] OP_PROG_FWD = 3'b101;
    localparam logic [2:0] OP_PROG_REV = 3'b110;

    // Unused codes 100 and 111 fall into the idle kind.
    function automatic op_kind_e decode_op(input logic [2:0] code);
        op_kind_e k;
        case (code)
            OP_FEED_FWD: k = K_FWD;
            OP_FEED_REV: k = K_REV;
            OP_SCAN:     k = K_SCAN;
            OP_PROG_FWD: k = K_PFWD;
            OP_PROG_REV: k = K_PREV;
            default:     k = K_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/smseq_ctrl_regs.sv
module smseq_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_wr,
    input  logic reg_standby,
    input  logic reg_swreset,
    output logic cmd_strobe,
    output logic halt_now,
    output logic standby_q
);
    logic swrst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            standby_q <= 1'b0;
            swrst_q   <= 1'b0;
        end else if (reg_wr) begin
            standby_q <= reg_standby;
            swrst_q   <= reg_swreset;
        end
    end

    // A code counts only on a plain write outside standby and reset hold.
    assign cmd_strobe = reg_wr && !reg_swreset && !reg_standby && !swrst_q && !standby_q;
    assign halt_now   = standby_q || swrst_q || (reg_wr && (reg_standby || reg_swreset));

    a_r10_standby_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_q && !reg_wr) |=> standby_q);

endmodule

// File: rtl/smseq_line_counter.sv
module smseq_line_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign last = (cnt_q == ONE);

    // R6: the count never wraps below zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> cnt_q == '0);

endmodule

// File: rtl/smseq_fsm.sv
module smseq_fsm
    import smseq_pkg::*;
#(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_now,
    input  logic              cmd_strobe,
    input  logic [2:0]        cmd_code,
    input  logic              line_tick,
    input  logic              count_zero,
    input  logic              cnt_last,
    input  logic [STEP_W-1:0] feed_step,
    output logic              cnt_load,
    output logic              cnt_dec,
    output logic              step_en,
    output logic              step_dir,
    output logic [STEP_W-1:0] step_size,
    output logic              scan_active,
    output logic              ptr_reset,
    output logic              busy,
    output logic [2:0]        cmd_status
);
    seq_state_e state_q, state_d;
    op_kind_e   op;
    logic       stop_req;
    logic       in_prog;

    assign op       = decode_op(cmd_code);
    assign stop_req = cmd_strobe && (op == K_IDLE);
    assign in_prog  = (state_q == ST_PROG_FWD) || (state_q == ST_PROG_REV);
    assign cnt_load = !halt_now && (state_q == ST_IDLE) && cmd_strobe
                      && (op == K_PFWD || op == K_PREV) && !count_zero;
    assign cnt_dec  = line_tick && in_prog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (halt_now) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_strobe) begin
                        case (op)
                            K_FWD:   state_d = ST_FEED_FWD;
                            K_REV:   state_d = ST_FEED_REV;
                            K_SCAN:  state_d = ST_PTR_CLR;
                            K_PFWD:  state_d = count_zero ? ST_IDLE : ST_PROG_FWD;
                            K_PREV:  state_d = count_zero ? ST_IDLE : ST_PROG_REV;
                            default: state_d = ST_IDLE;
                        endcase
                    end
                end
                ST_FEED_FWD, ST_FEED_REV: begin
                    if (stop_req) state_d = ST_IDLE;
                end
                ST_PTR_CLR: begin
                    state_d = stop_req ? ST_DRAIN : ST_SCAN;
                end
                ST_SCAN: begin
                    if (stop_req) state_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (line_tick) state_d = ST_IDLE;
                end
                ST_PROG_FWD, ST_PROG_REV: begin
                    if (stop_req || (line_tick && cnt_last)) state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        step_en     = 1'b0;
        step_dir    = 1'b0;
        step_size   = '0;
        scan_active = 1'b0;
        ptr_reset   = 1'b0;
        busy        = 1'b1;
        cmd_status  = OP_IDLE;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_FEED_FWD: begin
                step_en = 1'b1; step_size = feed_step; cmd_status = OP_FEED_FWD;
            end
            ST_FEED_REV: begin
                step_en = 1'b1; step_dir = 1'b1; step_size = feed_step; cmd_status = OP_FEED_REV;
            end
            ST_PTR_CLR: begin
                ptr_reset = 1'b1; cmd_status = OP_SCAN;
            end
            ST_SCAN: begin
                step_en = 1'b1; scan_active = 1'b1; cmd_status = OP_SCAN;
            end
            ST_DRAIN: begin
                step_en = 1'b1; scan_active = 1'b1;
            end
            ST_PROG_FWD: begin
                step_en = 1'b1; step_size = feed_step; cmd_status = OP_PROG_FWD;
            end
            ST_PROG_REV: begin
                step_en = 1'b1; step_dir = 1'b1; step_size = feed_step; cmd_status = OP_PROG_REV;
            end
        endcase
    end

    a_r4_ptr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_reset && !halt_now) |=> (!ptr_reset && scan_active));

    a_r5_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !line_tick && !halt_now) |=> state_q == ST_DRAIN);

    a_r7_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FEED_FWD) |=> (state_q == ST_FEED_FWD || state_q == ST_IDLE));

    a_r6_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_FWD && !halt_now && !cmd_strobe && !line_tick)
        |=> state_q == ST_PROG_FWD);

endmodule

// File: rtl/scan_motion_seq.sv
module scan_motion_seq #(
    parameter int CNT_W  = 16,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_cmd,
    input  logic              reg_standby,
    input  logic              reg_swreset,
    input  logic [CNT_W-1:0]  line_count,
    input  logic [STEP_W-1:0] feed_step,
    input  logic              line_tick,
    output logic              step_en,
    output logic              step_dir,
    output logic [STEP_W-1:0] step_size,
    output logic              scan_active,
    output logic              ptr_reset,
    output logic              busy,
    output logic [2:0]        cmd_status,
    output logic              sensor_clk_en
);
    logic cmd_strobe, halt_now, standby_q;
    logic cnt_load, cnt_dec, cnt_last;

    smseq_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_standby (reg_standby),
        .reg_swreset (reg_swreset),
        .cmd_strobe  (cmd_strobe),
        .halt_now    (halt_now),
        .standby_q   (standby_q)
    );

    smseq_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (halt_now),
        .load     (cnt_load),
        .load_val (line_count),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    smseq_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_now    (halt_now),
        .cmd_strobe  (cmd_strobe),
        .cmd_code    (reg_cmd),
        .line_tick   (line_tick),
        .count_zero  (line_count == '0),
        .cnt_last    (cnt_last),
        .feed_step   (feed_step),
        .cnt_load    (cnt_load),
        .cnt_dec     (cnt_dec),
        .step_en     (step_en),
        .step_dir    (step_dir),
        .step_size   (step_size),
        .scan_active (scan_active),
        .ptr_reset   (ptr_reset),
        .busy        (busy),
        .cmd_status  (cmd_status)
    );

    assign sensor_clk_en = !standby_q;

    a_r10_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        standby_q |-> (!step_en && !scan_active && !busy));

endmodule

// File: tb/scan_motion_seq_test.sv
`timescale 1ns/1ps
module scan_motion_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_cmd = 3'b000;
    logic        reg_standby = 1'b0;
    logic        reg_swreset = 1'b0;
    logic [15:0] line_count = 16'd0;
    logic [15:0] feed_step = 16'h0123;
    logic        line_tick = 1'b0;
    logic        step_en, step_dir, scan_active, ptr_reset, busy, sensor_clk_en;
    logic [15:0] step_size;
    logic [2:0]  cmd_status;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    scan_motion_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_cmd(reg_cmd),
        .reg_standby(reg_standby), .reg_swreset(reg_swreset),
        .line_count(line_count), .feed_step(feed_step), .line_tick(line_tick),
        .step_en(step_en), .step_dir(step_dir), .step_size(step_size),
        .scan_active(scan_active), .ptr_reset(ptr_reset), .busy(busy),
        .cmd_status(cmd_status), .sensor_clk_en(sensor_clk_en)
    );

    // Behavioural model: 0 idle, 1 fwd, 2 rev, 3 pointer clear, 4 scan,
    // 5 drain, 6 preset fwd, 7 preset rev
    int m_mode = 0;
    int m_rem = 0;
    bit m_sb = 0;
    bit m_sr = 0;
    int mode_log[$];

    always @(posedge clk) begin
        bit halt, strobe, idle_op;
        if (!rst_n) begin
            m_mode = 0; m_rem = 0; m_sb = 0; m_sr = 0;
        end else begin
            halt    = m_sb || m_sr || (reg_wr && (reg_standby || reg_swreset));
            strobe  = reg_wr && !reg_swreset && !reg_standby && !m_sr && !m_sb;
            idle_op = (reg_cmd == 3'd0) || (reg_cmd == 3'd4) || (reg_cmd == 3'd7);
            if (halt) begin
                m_mode = 0; m_rem = 0;
            end else begin
                case (m_mode)
                    0: if (strobe) begin
                        if (reg_cmd == 3'd1) m_mode = 1;
                        else if (reg_cmd == 3'd2) m_mode = 2;
                        else if (reg_cmd == 3'd3) m_mode = 3;
                        else if ((reg_cmd == 3'd5 || reg_cmd == 3'd6) && line_count != 0) begin
                            m_mode = (reg_cmd == 3'd5) ? 6 : 7;
                            m_rem = line_count;
                        end
                    end
                    1, 2: if (strobe && idle_op) m_mode = 0;
                    3: m_mode = (strobe && idle_op) ? 5 : 4;
                    4: if (strobe && idle_op) m_mode = 5;
                    5: if (line_tick) m_mode = 0;
                    default: begin
                        if (strobe && idle_op) m_mode = 0;
                        else if (line_tick) begin
                            if (m_rem == 1) m_mode = 0;
                            m_rem = m_rem - 1;
                        end
                    end
                endcase
            end
            if (reg_wr) begin m_sb = reg_standby; m_sr = reg_swreset; end
            mode_log.push_back(m_mode);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mode_log.size() > 0) begin
            int m;
            int st;
            m = mode_log.pop_front();
            case (m)
                1: st = 1; 2: st = 2; 3, 4: st = 3; 6: st = 5; 7: st = 6;
                default: st = 0;
            endcase
            chk("R2 step_en", step_en, (m != 0 && m != 3) ? 1 : 0);
            chk("R2 step_dir", step_dir, (m == 2 || m == 7) ? 1 : 0);
            chk("R4 scan_active", scan_active, (m == 4 || m == 5) ? 1 : 0);
            chk("R4 ptr_reset", ptr_reset, (m == 3) ? 1 : 0);
            chk("R7 busy", busy, (m != 0) ? 1 : 0);
            chk("R8 cmd_status", cmd_status, st);
            chk("R9 step_size", step_size,
                (m == 1 || m == 2 || m == 6 || m == 7) ? int'(feed_step) : 0);
            chk("R10 sensor_clk_en", sensor_clk_en, m_sb ? 0 : 1);
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask

    task automatic ctl(input bit sb, input bit sr, input logic [2:0] c);
        reg_wr = 1'b1; reg_cmd = c; reg_standby = sb; reg_swreset = sr;
        cyc();
        reg_wr = 1'b0; reg_standby = 1'b0; reg_swreset = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c); ctl(1'b0, 1'b0, c); endtask
    task automatic tick(); line_tick = 1'b1; cyc(); line_tick = 1'b0; endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 busy", busy, 0);
        chk("R1 step_en", step_en, 0);
        chk("R1 cmd_status", cmd_status, 0);
        chk("R1 sensor_clk_en", sensor_clk_en, 1);

        cmd(3'b001);
        chk("R2 fwd step_en", step_en, 1);
        chk("R2 fwd dir", step_dir, 0);
        repeat (3) cyc();
        cmd(3'b010);
        chk("R7 dir unchanged", step_dir, 0);
        chk("R7 still busy", busy, 1);
        feed_step = 16'h0456;
        cyc();
        chk("R9 follows feed_step", step_size, 16'h0456);
        cmd(3'b100);
        chk("R3 code 100 stops", busy, 0);

        cmd(3'b010);
        chk("R2 rev dir", step_dir, 1);
        cyc();
        cmd(3'b111);
        chk("R3 code 111 stops", step_en, 0);

        cmd(3'b011);
        chk("R4 pointer pulse", ptr_reset, 1);
        chk("R4 no scan yet", scan_active, 0);
        cyc();
        chk("R4 pulse ends", ptr_reset, 0);
        chk("R4 scanning", scan_active, 1);
        chk("R9 no step size in scan", step_size, 0);
        tick(); cyc(); tick();
        cmd(3'b000);
        chk("R5 drain keeps scan", scan_active, 1);
        chk("R8 drain status", cmd_status, 0);
        repeat (3) cyc();
        chk("R5 waits for line", busy, 1);
        tick();
        chk("R5 done after tick", busy, 0);
        chk("R5 scan off", scan_active, 0);

        line_count = 16'd3;
        cmd(3'b101);
        chk("R6 preset fwd", busy, 1);
        chk("R8 preset status", cmd_status, 5);
        chk("R9 preset size", step_size, 16'h0456);
        cmd(3'b011);
        chk("R7 scan ignored", ptr_reset, 0);
        chk("R7 status kept", cmd_status, 5);
        tick(); cyc(); tick();
        chk("R6 two of three", busy, 1);
        tick();
        chk("R6 ends on third", busy, 0);
        chk("R6 status cleared", cmd_status, 0);

        line_count = 16'd2;
        cmd(3'b110);
        chk("R6 preset rev dir", step_dir, 1);
        chk("R8 rev status", cmd_status, 6);
        tick();
        chk("R6 one of two", busy, 1);
        tick();
        chk("R6 rev ends", busy, 0);

        line_count = 16'd0;
        cmd(3'b101);
        chk("R6 zero count no move", busy, 0);

        line_count = 16'd50;
        cmd(3'b101);
        tick();
        cmd(3'b000);
        chk("R3 abort preset", step_en, 0);

        cmd(3'b001);
        ctl(1'b1, 1'b0, 3'b001);
        chk("R10 standby halts", step_en, 0);
        chk("R10 clock gated", sensor_clk_en, 0);
        ctl(1'b1, 1'b0, 3'b010);
        chk("R10 ignored in standby", busy, 0);
        cmd(3'b001);
        chk("R10 exit write ignored", busy, 0);
        chk("R10 clock back", sensor_clk_en, 1);
        cmd(3'b001);
        chk("R10 accepts after exit", busy, 1);
        cmd(3'b000);

        cmd(3'b011);
        cyc();
        ctl(1'b0, 1'b1, 3'b000);
        chk("R11 reset stops scan", scan_active, 0);
        chk("R11 reset idle", busy, 0);
        ctl(1'b0, 1'b1, 3'b001);
        chk("R11 held in reset", busy, 0);
        ctl(1'b0, 1'b0, 3'b001);
        chk("R11 release code ignored", busy, 0);
        cmd(3'b010);
        chk("R11 accepts after release", busy, 1);
        cmd(3'b000);
        repeat (3) cyc();

        finish_run();
    end
endmodule